// File: doc/BRIEF.md
# Two-Channel Double-Data-Rate Sample Serializer

This block turns sets of parallel 12-bit I/Q samples for two transceiver channels into a narrow stream. The stream carries 6 bits on the rising edge and 6 bits on the falling edge of each clock, plus a frame bit. Each 12-bit sample is cut into an upper half (bits 11:6) and a lower half (bits 5:0). In every clock cycle the rising-edge lane carries an I half and the falling-edge lane carries the matching Q half. Within one channel the upper halves go out first. Channel 1 is sent completely before channel 2, so one set of four samples takes four cycles, which is eight edges. The output DDR cells and the pad buffers sit outside this block. They take the two 6-bit lanes and the frame bit as they are.

Sets arrive on a valid/ready port. `s_ready` is high while the block is idle and in the last cycle of each set. A set is taken in any cycle where `s_valid` and `s_ready` are both high. Its first half-pair appears on the outputs in the following cycle. While `s_ready` is low, the source must hold its data, and nothing it offers is taken. If the source has no valid set at a set boundary, the serializer sends the previous set again and raises a sticky underflow flag. Before the first set is taken, the lanes and the frame bit stay at zero.

Top module: `ddr_pair_serializer`

## Requirements
- R1: After reset, `frame`, `ddr_rise`, `ddr_fall` and `underflow` are all zero and `s_ready` is one. A later reset clears a raised `underflow`.
- R2: Within a channel slot, the first cycle carries I[11:6] on `ddr_rise` and Q[11:6] on `ddr_fall`. The second cycle carries I[5:0] on `ddr_rise` and Q[5:0] on `ddr_fall`.
- R3: Channel 1 (bits 11:0 of `s_i`/`s_q`) occupies cycles 0 and 1 of a set. Channel 2 (bits 23:12) occupies cycles 2 and 3. The next set begins in cycle 4.
- R4: `frame` is one in cycles that carry upper halves and zero in cycles that carry lower halves, so it toggles every cycle once the block is running.
- R5: `s_ready` is one only while the block is idle and in the last cycle of a set. A handshake loads the set, and the set's first half-pair appears in the next cycle. Data offered while `s_ready` is zero is not taken.
- R6: Until the first handshake after reset, the lanes and `frame` stay zero.
- R7: When `s_valid` is low in the last cycle of a running set, `underflow` rises one cycle later and stays high until reset.
- R8: On such a miss, the previous set is sent again, in full and in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both edges of the stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | The source offers a set |
| s_ready | output | 1 | The block takes a set in this cycle |
| s_i | input | 24 | I samples; channel 1 in [11:0], channel 2 in [23:12] |
| s_q | input | 24 | Q samples; same layout as `s_i` |
| ddr_rise | output | 6 | Half-sample sent on the rising edge (I half) |
| ddr_fall | output | 6 | Half-sample sent on the falling edge (Q half) |
| frame | output | 1 | High during upper-half cycles |
| underflow | output | 1 | Sticky: a set boundary passed with no valid input |

## Verification
A slot counter that skips or repeats a count shows up at once on the ports. `frame` stops alternating in that cycle, and `s_ready` opens at the wrong distance from the last handshake. A capture register that loads at the wrong moment, or misses a load, puts wrong half-samples on the lanes in the very next cycle. A lost or spurious underflow flag is visible on the port one cycle after the boundary that should have set it. Because the bench compares all lanes, the frame bit, `s_ready` and `underflow` against its model every cycle, each of these faults is reported within one set, four cycles at most.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;

  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;

  function automatic half_e half_of_slot(input logic slot_lsb);
    return slot_lsb ? HALF_LOWER : HALF_UPPER;
  endfunction

endpackage

// File: rtl/ddrser_slot_ctr.sv
module ddrser_slot_ctr #(
  parameter int SLOTS = 4,
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  output logic [PW-1:0] slot,
  output logic          running,
  output logic          last_slot
);

  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      slot    <= '0;
    end else if (accept) begin
      running <= 1'b1;
      slot    <= '0;
    end else if (running) begin
      slot <= (slot == LAST) ? '0 : slot + 1'b1;
    end
  end

  assign last_slot = running && (slot == LAST);

  // R5: a running block stays in its last slot for exactly one cycle
  a_r5_last_slot_single : assert property (@(posedge clk) disable iff (!rst_n)
    last_slot |=> !last_slot);

endmodule

// File: rtl/ddrser_capture.sv
module ddrser_capture #(
  parameter int CHANNELS = 2,
  parameter int SAMPLE_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic                         miss,
  input  logic [CHANNELS*SAMPLE_W-1:0] in_i,
  input  logic [CHANNELS*SAMPLE_W-1:0] in_q,
  output logic [CHANNELS*SAMPLE_W-1:0] held_i,
  output logic [CHANNELS*SAMPLE_W-1:0] held_q,
  output logic                         underflow
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_i <= '0;
      held_q <= '0;
    end else if (accept) begin
      held_i <= in_i;
      held_q <= in_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) underflow <= 1'b0;
    else if (miss) underflow <= 1'b1;
  end

  // R7: the underflow flag never drops without a reset
  a_r7_underflow_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  // R8: a missed boundary keeps the held set for the repeat
  a_r8_repeat_keeps_set : assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> ($stable(held_i) && $stable(held_q)));

endmodule

// File: rtl/ddrser_lane_sel.sv
module ddrser_lane_sel
  import ddrser_pkg::*;
#(
  parameter int CHANNELS = 2,
  parameter int SAMPLE_W = 12,
  localparam int SLOTS = 2 * CHANNELS,
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int HW = SAMPLE_W / 2,
  localparam int CW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic [CHANNELS*SAMPLE_W-1:0] held_i,
  input  logic [CHANNELS*SAMPLE_W-1:0] held_q,
  input  logic [PW-1:0]                slot,
  input  logic                         running,
  output logic [HW-1:0]                lane_rise,
  output logic [HW-1:0]                lane_fall,
  output logic                         frame
);

  logic [CHANNELS-1:0][HW-1:0] up_i, lo_i, up_q, lo_q;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_split
    assign up_i[c] = held_i[c*SAMPLE_W + HW +: HW];
    assign lo_i[c] = held_i[c*SAMPLE_W      +: HW];
    assign up_q[c] = held_q[c*SAMPLE_W + HW +: HW];
    assign lo_q[c] = held_q[c*SAMPLE_W      +: HW];
  end

  logic [CW-1:0] ch_sel;
  half_e         half;

  assign ch_sel = CW'(slot >> 1);
  assign half   = half_of_slot(slot[0]);

  always_comb begin
    lane_rise = '0;
    lane_fall = '0;
    frame     = 1'b0;
    if (running) begin
      if (half == HALF_UPPER) begin
        lane_rise = up_i[ch_sel];
        lane_fall = up_q[ch_sel];
        frame     = 1'b1;
      end else begin
        lane_rise = lo_i[ch_sel];
        lane_fall = lo_q[ch_sel];
      end
    end
  end

endmodule

// File: rtl/ddr_pair_serializer.sv
module ddr_pair_serializer #(
  parameter int SAMPLE_W = 12,
  parameter int CHANNELS = 2,
  localparam int HW = SAMPLE_W / 2,
  localparam int SLOTS = 2 * CHANNELS,
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [CHANNELS*SAMPLE_W-1:0] s_i,
  input  logic [CHANNELS*SAMPLE_W-1:0] s_q,
  output logic [HW-1:0]                ddr_rise,
  output logic [HW-1:0]                ddr_fall,
  output logic                         frame,
  output logic                         underflow
);

  logic [PW-1:0]                slot;
  logic                         running, last_slot, accept, miss;
  logic [CHANNELS*SAMPLE_W-1:0] held_i, held_q;

  assign s_ready = !running || last_slot;
  assign accept  = s_valid && s_ready;
  assign miss    = last_slot && !s_valid;

  ddrser_slot_ctr #(.SLOTS(SLOTS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .slot(slot), .running(running), .last_slot(last_slot)
  );

  ddrser_capture #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept), .miss(miss),
    .in_i(s_i), .in_q(s_q), .held_i(held_i), .held_q(held_q),
    .underflow(underflow)
  );

  ddrser_lane_sel #(.CHANNELS(CHANNELS), .SAMPLE_W(SAMPLE_W)) u_sel (
    .held_i(held_i), .held_q(held_q), .slot(slot), .running(running),
    .lane_rise(ddr_rise), .lane_fall(ddr_fall), .frame(frame)
  );

  // R4: frame alternates every cycle while running
  a_r4_frame_toggles : assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (frame != $past(frame)));

  // R5: after a running-state ready cycle, ready is low
  a_r5_ready_gap : assert property (@(posedge clk) disable iff (!rst_n)
    (running && s_ready) |=> !s_ready);

  // R2: the cycle after a handshake carries channel 1 I upper half
  a_r2_first_half : assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (frame && ddr_rise == $past(s_i[SAMPLE_W-1:HW])
                              && ddr_fall == $past(s_q[SAMPLE_W-1:HW])));

  // R6: idle outputs are quiet and the port is open
  a_r6_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (ddr_rise == '0 && ddr_fall == '0 && !frame && s_ready));

endmodule

// File: tb/sim_ddr_pair_serializer.sv
`timescale 1ns/1ps
module sim_ddr_pair_serializer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_i = '0, s_q = '0;
  logic [5:0]  ddr_rise, ddr_fall;
  logic        frame, underflow;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  ddr_pair_serializer u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .ddr_rise(ddr_rise), .ddr_fall(ddr_fall),
    .frame(frame), .underflow(underflow)
  );

  // behavioural reference model
  logic [23:0] m_i = '0, m_q = '0;
  int m_cnt = 0;
  bit m_run = 0, m_uf = 0, m_rep = 0, m_acc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_i = '0; m_q = '0; m_cnt = 0; m_run = 0; m_uf = 0; m_rep = 0; m_acc = 0;
    end else begin
      bit rdy;
      rdy = !m_run || (m_cnt == 3);
      m_acc = s_valid && rdy;
      if (m_acc) begin
        m_i = s_i; m_q = s_q; m_run = 1; m_cnt = 0; m_rep = 0;
      end else if (m_run) begin
        if (m_cnt == 3) begin
          m_cnt = 0; m_uf = 1; m_rep = 1;
        end else m_cnt++;
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [5:0] e_rise, e_fall;
    bit e_frame;
    string tag;
    int ch;
    ch = m_cnt / 2;
    if (!m_run) begin
      e_rise = '0; e_fall = '0; e_frame = 0; tag = "R6";
    end else begin
      e_frame = (m_cnt % 2 == 0);
      e_rise  = e_frame ? m_i[ch*12+6 +: 6] : m_i[ch*12 +: 6];
      e_fall  = e_frame ? m_q[ch*12+6 +: 6] : m_q[ch*12 +: 6];
      tag = m_rep ? "R8" : (ch == 1 ? "R3" : "R2");
    end
    check(tag,  "ddr_rise",  32'(ddr_rise), 32'(e_rise));
    check(tag,  "ddr_fall",  32'(ddr_fall), 32'(e_fall));
    check("R4", "frame",     32'(frame),    32'(e_frame));
    check("R5", "s_ready",   32'(s_ready),  32'(!m_run || m_cnt == 3));
    check("R7", "underflow", 32'(underflow), 32'(m_uf));
  endtask

  // mode 0: valid always, 1: never, 2: random
  task automatic step(input int mode);
    @(negedge clk);
    compare_all();
    if (m_acc || !s_valid) begin
      s_i = 24'($urandom);
      s_q = 24'($urandom);
    end
    case (mode)
      0: s_valid = 1'b1;
      1: s_valid = 1'b0;
      default: s_valid = (s_valid && !m_acc) ? 1'b1 : 1'($urandom_range(0, 1));
    endcase
  endtask

  task automatic run(input int n, input int mode);
    for (int k = 0; k < n; k++) step(mode);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "frame",     32'(frame),     32'd0);
    check("R1", "ddr_rise",  32'(ddr_rise),  32'd0);
    check("R1", "ddr_fall",  32'(ddr_fall),  32'd0);
    check("R1", "underflow", 32'(underflow), 32'd0);
    check("R1", "s_ready",   32'(s_ready),   32'd1);
    rst_n = 1'b1;
    run(6, 1);     // R6 idle
    run(40, 0);    // back-to-back sets
    run(13, 1);    // R7/R8 starvation
    run(200, 2);   // random valid, R5 hold rules
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "underflow after reset", 32'(underflow), 32'd0);
    check("R1", "frame after reset",     32'(frame),     32'd0);
    s_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run(20, 0);
    run(300, 2);
    run(9, 1);
    run(20, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule